// File: doc/BRIEF.md
# Byte SEC Hamming Datapath with Isolated Test Readouts

This block sits between the external byte bus and a byte-wide nonvolatile array. Each byte written from the bus is stored with four check bits, forming a 12-bit word, and on every normal read the block corrects any single flipped bit of that word before the byte reaches the bus. A one-cycle flag reports each read whose syndrome was non-zero.

Three test inputs let production test reach each part of the protection in isolation. The first closes a loop from the bus input through the check-bit generator to the bus output, without touching the array. The second returns the stored data bits exactly as read. The third returns the stored check bits in place of the data. A stored configuration bit can also switch the block to uncorrected reads without any test input. Each byte of a multi-byte page is encoded on its own, so page writes need nothing special here.

A read is requested by pulling the active-low output enable while no write is requested. Its result appears on the registered data output together with a valid strobe. The array port is assumed to return a word one cycle after it is addressed.

Top module: `secded_byte_port`

## Requirements
- R1: A write request (wr_en high at a clock edge) drives arr_we high for the next cycle, with arr_waddr equal to addr and arr_wdata the 12-bit codeword of din. Word bit p-1 holds Hamming position p. The check bits c1, c2, c4 and c8 sit at positions 1, 2, 4 and 8, and the data bits d0..d7 fill positions 3, 5, 6, 7, 9, 10, 11 and 12 in that order. Each check bit ck is the XOR of the data bits whose position has bit value k set.
- R2: In normal mode, a word with a single inverted bit at any of the 12 positions returns the originally written byte.
- R3: err_fix is high for exactly the cycle in which dout_vld presents a normal-mode read with a non-zero syndrome, and it is low in every other cycle.
- R4: With tm_gen high, a read does not access the array (arr_re stays low), din is captured with the request, and dout returns {4'b0, c8, c4, c2, c1} computed from that din.
- R5: With tm_raw high (and no higher-priority test input), dout returns the stored data bits d7..d0 without correction, and err_fix stays low.
- R6: With tm_chk high (and tm_gen low), dout returns {4'b0, c8, c4, c2, c1} exactly as stored. Whenever check bits are on dout, bits 7:4 are zero.
- R7: When several test inputs are high, tm_gen wins over tm_chk, and tm_chk wins over tm_raw.
- R8: A cycle with cfg_we high loads cfg_val into a configuration bit that holds until it is next written, and reset clears it. While it is 1, reads without a test input behave as tm_raw reads.
- R9: A read request is oe_n low with wr_en low at a clock edge. dout and dout_vld update at the second edge after the request, and dout_vld is low after the first. If wr_en and oe_n low coincide, only the write takes place.
- R10: In any cycle with dout_vld low, dout keeps its previous value.
- R11: After reset, dout is 0, and dout_vld, err_fix and arr_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address for reads and writes |
| din | input | 8 | Byte from the external bus |
| wr_en | input | 1 | Write request |
| oe_n | input | 1 | Active-low output enable; requests a read |
| tm_gen | input | 1 | Test: check-bit generator loopback |
| tm_chk | input | 1 | Test: stored check-bit readout |
| tm_raw | input | 1 | Test: uncorrected data readout |
| cfg_we | input | 1 | Load strobe for the correction-off configuration bit |
| cfg_val | input | 1 | Value loaded into the configuration bit |
| arr_we | output | 1 | Array write strobe |
| arr_waddr | output | ADDR_W | Array write address |
| arr_wdata | output | 12 | Codeword to store |
| arr_re | output | 1 | Array read strobe |
| arr_raddr | output | ADDR_W | Array read address |
| arr_rdata | input | 12 | Stored word, valid one cycle after arr_re |
| dout | output | 8 | Registered byte to the external bus |
| dout_vld | output | 1 | dout carries a new read result |
| err_fix | output | 1 | Non-zero syndrome seen on this normal read |

## Verification
The case that needs care is a write request and a read request arriving in the same cycle. The write has to take the array while the read produces no result, and the pending write must not disturb a read already in flight. The bench raises wr_en and lowers oe_n together and checks that dout_vld stays low two edges later. It then reads the same address back and expects the newly written byte. Random stimulus also mixes single-bit corruption of the stored word with every test-input combination, and each read is judged against codewords that the bench builds itself.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 8;
  localparam int CHK_W  = 4;
  localparam int WORD_W = DATA_W + CHK_W;

  typedef enum logic [1:0] {
    RD_NORMAL     = 2'd0,
    RD_GENCHK     = 2'd1,
    RD_STORED_CHK = 2'd2,
    RD_RAW        = 2'd3
  } rd_mode_e;

  function automatic logic is_chk_pos(int pos);
    return (pos & (pos - 1)) == 0;
  endfunction

  // Spread data bits over the non power-of-two positions, lowest first.
  function automatic logic [WORD_W-1:0] place_data(logic [DATA_W-1:0] d);
    logic [WORD_W-1:0] w;
    int k;
    w = '0;
    k = 0;
    for (int pos = 1; pos <= WORD_W; pos++) begin
      if (!is_chk_pos(pos)) begin
        w[pos-1] = d[k];
        k++;
      end
    end
    return w;
  endfunction

  // XOR of the positions of all set bits.
  function automatic logic [CHK_W-1:0] syndrome(logic [WORD_W-1:0] w);
    logic [CHK_W-1:0] s;
    s = '0;
    for (int pos = 1; pos <= WORD_W; pos++) begin
      if (w[pos-1]) s = s ^ CHK_W'(pos);
    end
    return s;
  endfunction

  function automatic logic [DATA_W-1:0] extract_data(logic [WORD_W-1:0] w);
    logic [DATA_W-1:0] d;
    int k;
    d = '0;
    k = 0;
    for (int pos = 1; pos <= WORD_W; pos++) begin
      if (!is_chk_pos(pos)) begin
        d[k] = w[pos-1];
        k++;
      end
    end
    return d;
  endfunction

  function automatic logic [CHK_W-1:0] extract_chk(logic [WORD_W-1:0] w);
    logic [CHK_W-1:0] c;
    for (int j = 0; j < CHK_W; j++) c[j] = w[(1 << j) - 1];
    return c;
  endfunction
endpackage

// File: rtl/secded_encoder.sv
module secded_encoder
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb begin
    logic [WORD_W-1:0] w;
    logic [CHK_W-1:0]  s;
    w = place_data(data_i);
    s = syndrome(w);
    for (int j = 0; j < CHK_W; j++) w[(1 << j) - 1] = s[j];
    word_o = w;
  end
endmodule

// File: rtl/secded_decoder.sv
module secded_decoder
  import secded_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [DATA_W-1:0] data_fixed_o,
  output logic [DATA_W-1:0] data_raw_o,
  output logic [CHK_W-1:0]  chk_raw_o,
  output logic              syn_nz_o
);
  logic [CHK_W-1:0]  syn;
  logic [WORD_W-1:0] flip;

  always_comb begin
    syn  = syndrome(word_i);
    flip = '0;
    if (syn != '0 && syn <= CHK_W'(WORD_W))
      flip = WORD_W'(1) << (syn - CHK_W'(1));
    data_fixed_o = extract_data(word_i ^ flip);
    data_raw_o   = extract_data(word_i);
    chk_raw_o    = extract_chk(word_i);
    syn_nz_o     = (syn != '0);
  end
endmodule

// File: rtl/rd_mode_arb.sv
module rd_mode_arb
  import secded_pkg::*;
(
  input  logic     tm_gen_i,
  input  logic     tm_chk_i,
  input  logic     tm_raw_i,
  input  logic     cfg_off_i,
  output rd_mode_e mode_o
);
  always_comb begin
    if (tm_gen_i)                  mode_o = RD_GENCHK;
    else if (tm_chk_i)             mode_o = RD_STORED_CHK;
    else if (tm_raw_i || cfg_off_i) mode_o = RD_RAW;
    else                           mode_o = RD_NORMAL;
  end
endmodule

// File: rtl/secded_byte_port.sv
module secded_byte_port
  import secded_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              wr_en,
  input  logic              oe_n,
  input  logic              tm_gen,
  input  logic              tm_chk,
  input  logic              tm_raw,
  input  logic              cfg_we,
  input  logic              cfg_val,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_waddr,
  output logic [WORD_W-1:0] arr_wdata,
  output logic              arr_re,
  output logic [ADDR_W-1:0] arr_raddr,
  input  logic [WORD_W-1:0] arr_rdata,
  output logic [DATA_W-1:0] dout,
  output logic              dout_vld,
  output logic              err_fix
);
  localparam int PAD_W = DATA_W - CHK_W;

  logic              rd_req;
  rd_mode_e          cur_mode;
  logic              ecc_off_q;
  logic              rd_p1_q;
  rd_mode_e          mode_p1_q;
  rd_mode_e          out_mode_q;
  logic [DATA_W-1:0] lat_q;
  logic [WORD_W-1:0] enc_word;
  logic [WORD_W-1:0] gen_word;
  logic [DATA_W-1:0] dec_fixed;
  logic [DATA_W-1:0] dec_raw;
  logic [CHK_W-1:0]  dec_chk;
  logic              dec_nz;
  logic              live_q;

  assign rd_req    = !oe_n && !wr_en;
  assign arr_re    = rd_req && (cur_mode != RD_GENCHK);
  assign arr_raddr = addr;

  rd_mode_arb u_arb (
    .tm_gen_i (tm_gen),
    .tm_chk_i (tm_chk),
    .tm_raw_i (tm_raw),
    .cfg_off_i(ecc_off_q),
    .mode_o   (cur_mode)
  );

  secded_encoder u_enc_wr (.data_i(din),   .word_o(enc_word));
  secded_encoder u_enc_lb (.data_i(lat_q), .word_o(gen_word));

  secded_decoder u_dec (
    .word_i      (arr_rdata),
    .data_fixed_o(dec_fixed),
    .data_raw_o  (dec_raw),
    .chk_raw_o   (dec_chk),
    .syn_nz_o    (dec_nz)
  );

  // Write side and configuration bit.
  always_ff @(posedge clk) begin
    if (rst) begin
      arr_we    <= 1'b0;
      arr_waddr <= '0;
      arr_wdata <= '0;
      ecc_off_q <= 1'b0;
    end else begin
      arr_we <= wr_en;
      if (wr_en) begin
        arr_waddr <= addr;
        arr_wdata <= enc_word;
      end
      if (cfg_we) ecc_off_q <= cfg_val;
    end
  end

  // Read pipeline: request stage, then result stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_p1_q    <= 1'b0;
      mode_p1_q  <= RD_NORMAL;
      out_mode_q <= RD_NORMAL;
      lat_q      <= '0;
      dout       <= '0;
      dout_vld   <= 1'b0;
      err_fix    <= 1'b0;
      live_q     <= 1'b0;
    end else begin
      live_q  <= 1'b1;
      rd_p1_q <= rd_req;
      if (rd_req) begin
        mode_p1_q <= cur_mode;
        if (cur_mode == RD_GENCHK) lat_q <= din;
      end
      dout_vld <= rd_p1_q;
      err_fix  <= rd_p1_q && (mode_p1_q == RD_NORMAL) && dec_nz;
      if (rd_p1_q) begin
        out_mode_q <= mode_p1_q;
        case (mode_p1_q)
          RD_GENCHK:     dout <= {{PAD_W{1'b0}}, extract_chk(gen_word)};
          RD_STORED_CHK: dout <= {{PAD_W{1'b0}}, dec_chk};
          RD_RAW:        dout <= dec_raw;
          default:       dout <= dec_fixed;
        endcase
      end
    end
  end

  // R1: every word sent to the array is a clean codeword
  a_r1_clean_codeword: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> (syndrome(arr_wdata) == '0));

  // R3: the correction flag only accompanies a presented result
  a_r3_flag_with_vld: assert property (@(posedge clk) disable iff (rst)
    err_fix |-> dout_vld);

  // R4: loopback reads never touch the array
  a_r4_no_array_in_loop: assert property (@(posedge clk) disable iff (rst)
    tm_gen |-> !arr_re);

  // R6: check-bit readouts keep the upper nibble zero
  a_r6_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (dout_vld && (out_mode_q == RD_GENCHK || out_mode_q == RD_STORED_CHK))
      |-> (dout[DATA_W-1:CHK_W] == '0));

  // R7: test input priority
  a_r7_gen_first: assert property (@(posedge clk) disable iff (rst)
    tm_gen |-> (cur_mode == RD_GENCHK));
  a_r7_chk_second: assert property (@(posedge clk) disable iff (rst)
    (!tm_gen && tm_chk) |-> (cur_mode == RD_STORED_CHK));

  // R10: output holds between results
  a_r10_hold: assert property (@(posedge clk) disable iff (rst || !live_q)
    !dout_vld |-> $stable(dout));
endmodule

// File: tb/secded_byte_port_tb_top.sv
module secded_byte_port_tb_top;
  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic          wr_en = 1'b0, oe_n = 1'b1;
  logic          tm_gen = 1'b0, tm_chk = 1'b0, tm_raw = 1'b0;
  logic          cfg_we = 1'b0, cfg_val = 1'b0;
  logic          arr_we, arr_re;
  logic [AW-1:0] arr_waddr, arr_raddr;
  logic [11:0]   arr_wdata;
  logic [11:0]   arr_rdata = '0;
  logic [7:0]    dout;
  logic          dout_vld, err_fix;

  logic          inj_en = 1'b0;
  logic [7:0]    inj_addr = '0;
  logic [11:0]   inj_mask = '0;
  logic [11:0]   mem [256];

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  secded_byte_port #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .din(din), .wr_en(wr_en), .oe_n(oe_n),
    .tm_gen(tm_gen), .tm_chk(tm_chk), .tm_raw(tm_raw),
    .cfg_we(cfg_we), .cfg_val(cfg_val),
    .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
    .arr_re(arr_re), .arr_raddr(arr_raddr), .arr_rdata(arr_rdata),
    .dout(dout), .dout_vld(dout_vld), .err_fix(err_fix)
  );

  // Array model: synchronous write, one-cycle read, bit-flip injection.
  always @(posedge clk) begin
    if (arr_we) mem[arr_waddr[7:0]] <= arr_wdata;
    else if (inj_en) mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
    if (arr_re) arr_rdata <= mem[arr_raddr[7:0]];
  end

  function automatic logic [11:0] tb_enc(logic [7:0] d);
    logic c1, c2, c4, c8;
    c1 = d[0] ^ d[1] ^ d[3] ^ d[4] ^ d[6];
    c2 = d[0] ^ d[2] ^ d[3] ^ d[5] ^ d[6];
    c4 = d[1] ^ d[2] ^ d[3] ^ d[7];
    c8 = d[4] ^ d[5] ^ d[6] ^ d[7];
    return {d[7], d[6], d[5], d[4], c8, d[3], d[2], d[1], c4, d[0], c2, c1};
  endfunction

  function automatic logic [7:0] tb_data(logic [11:0] w);
    return {w[11], w[10], w[9], w[8], w[6], w[5], w[4], w[2]};
  endfunction

  function automatic logic [7:0] tb_chk(logic [11:0] w);
    return {4'b0, w[7], w[3], w[1], w[0]};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check("R1 arr_we", 32'(arr_we), 32'd1);
    check("R1 arr_waddr", 32'(arr_waddr), 32'(a));
    check("R1 arr_wdata", 32'(arr_wdata), 32'(tb_enc(d)));
    @(negedge clk);
  endtask

  task automatic inject(logic [7:0] a, int pos);
    if (pos == 0) return;
    @(negedge clk);
    inj_addr = a; inj_mask = 12'(1) << (pos - 1); inj_en = 1'b1;
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  task automatic do_read(logic [AW-1:0] a, logic g, logic c, logic r, logic [7:0] dn,
                         output logic [7:0] q, output logic v, output logic f,
                         output logic re);
    @(negedge clk);
    addr = a; din = dn; tm_gen = g; tm_chk = c; tm_raw = r; oe_n = 1'b0;
    #1 re = arr_re;
    @(negedge clk);
    oe_n = 1'b1; tm_gen = 1'b0; tm_chk = 1'b0; tm_raw = 1'b0;
    check("R9 vld low after first edge", 32'(dout_vld), 32'd0);
    @(negedge clk);
    q = dout; v = dout_vld; f = err_fix;
  endtask

  initial begin
    logic [7:0]  q, exp_q, d, dn;
    logic        v, f, re, g, c, r, cfgb, exp_f;
    logic [11:0] w;
    logic [AW-1:0] a;
    int          pos;
    int          seed_sink;

    seed_sink = $urandom(32'h1A2B);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R11 dout", 32'(dout), 32'd0);
    check("R11 dout_vld", 32'(dout_vld), 32'd0);
    check("R11 err_fix", 32'(err_fix), 32'd0);
    check("R11 arr_we", 32'(arr_we), 32'd0);

    // R2 R3: single flip at every position
    for (int p = 1; p <= 12; p++) begin
      do_write(15'h0105, 8'h3C);
      inject(8'h05, p);
      do_read(15'h0105, 0, 0, 0, 8'h00, q, v, f, re);
      check("R2 corrected byte", 32'(q), 32'h3C);
      check("R3 flag on flip", 32'(f), 32'd1);
      check("R9 vld at second edge", 32'(v), 32'd1);
    end

    // R3 clean read, R10 hold
    do_write(15'h7FFF, 8'hA5);
    do_read(15'h7FFF, 0, 0, 0, 8'h00, q, v, f, re);
    check("R2 clean byte", 32'(q), 32'hA5);
    check("R3 no flag when clean", 32'(f), 32'd0);
    @(negedge clk);
    check("R10 dout held", 32'(dout), 32'hA5);
    check("R10 vld low idle", 32'(dout_vld), 32'd0);
    check("R3 flag low idle", 32'(err_fix), 32'd0);

    // R5 raw readout of corrupted word
    do_write(15'h0010, 8'h5A);
    inject(8'h10, 9);
    do_read(15'h0010, 0, 0, 1, 8'h00, q, v, f, re);
    check("R5 raw data", 32'(q), 32'(tb_data(tb_enc(8'h5A) ^ 12'h100)));
    check("R5 no flag", 32'(f), 32'd0);

    // R6 stored check bits
    inject(8'h10, 4);
    do_read(15'h0010, 0, 1, 0, 8'h00, q, v, f, re);
    check("R6 stored checks", 32'(q), 32'(tb_chk(tb_enc(8'h5A) ^ 12'h108)));

    // R4 loopback
    do_read(15'h0010, 1, 0, 0, 8'h96, q, v, f, re);
    check("R4 arr_re low", 32'(re), 32'd0);
    check("R4 generated checks", 32'(q), 32'(tb_chk(tb_enc(8'h96))));

    // R7 priority
    do_read(15'h0010, 1, 1, 1, 8'h0F, q, v, f, re);
    check("R7 gen wins", 32'(q), 32'(tb_chk(tb_enc(8'h0F))));
    do_read(15'h0010, 0, 1, 1, 8'h00, q, v, f, re);
    check("R7 chk over raw", 32'(q), 32'(tb_chk(tb_enc(8'h5A) ^ 12'h108)));

    // R8 configuration bit
    do_write(15'h0020, 8'hC3);
    inject(8'h20, 6);
    @(negedge clk); cfg_we = 1'b1; cfg_val = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
    do_read(15'h0020, 0, 0, 0, 8'h00, q, v, f, re);
    check("R8 cfg gives raw", 32'(q), 32'(tb_data(tb_enc(8'hC3) ^ 12'h020)));
    check("R8 cfg no flag", 32'(f), 32'd0);
    @(negedge clk); cfg_we = 1'b1; cfg_val = 1'b0;
    @(negedge clk); cfg_we = 1'b0;
    do_read(15'h0020, 0, 0, 0, 8'h00, q, v, f, re);
    check("R8 cfg cleared corrects", 32'(q), 32'hC3);

    // R9 write and read requested together
    @(negedge clk);
    addr = 15'h0030; din = 8'h11; wr_en = 1'b1; oe_n = 1'b0;
    #1 check("R9 no array read on collision", 32'(arr_re), 32'd0);
    @(negedge clk); wr_en = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    check("R9 no result on collision", 32'(dout_vld), 32'd0);
    do_read(15'h0030, 0, 0, 0, 8'h00, q, v, f, re);
    check("R9 collision write landed", 32'(q), 32'h11);

    // Random mix
    for (int i = 0; i < 300; i++) begin
      a    = AW'($urandom);
      d    = 8'($urandom);
      dn   = 8'($urandom);
      pos  = ($urandom % 2) ? int'($urandom % 12) + 1 : 0;
      g    = ($urandom % 5) == 0;
      c    = ($urandom % 4) == 0;
      r    = ($urandom % 4) == 0;
      cfgb = ($urandom % 6) == 0;
      @(negedge clk); cfg_we = 1'b1; cfg_val = cfgb;
      @(negedge clk); cfg_we = 1'b0;
      do_write(a, d);
      inject(a[7:0], pos);
      w = tb_enc(d) ^ ((pos == 0) ? 12'h000 : (12'(1) << (pos - 1)));
      exp_f = 1'b0;
      if (g)             exp_q = tb_chk(tb_enc(dn));
      else if (c)        exp_q = tb_chk(w);
      else if (r || cfgb) exp_q = tb_data(w);
      else begin
        exp_q = d;
        exp_f = (pos != 0);
      end
      do_read(a, g, c, r, dn, q, v, f, re);
      check("R2 R4 R5 R6 R7 R8 random dout", 32'(q), 32'(exp_q));
      check("R3 random flag", 32'(f), 32'(exp_f));
      check("R9 random vld", 32'(v), 32'd1);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule